// File: doc/BRIEF.md
# Direct-Mapped Cache Controller

This block places a single-level, direct-mapped cache between a processor request port and a simple word-wide main-memory port. Each word address is split into three fields: a word offset inside a block, a line index and a tag. Every access looks at exactly one tag entry, the one selected by the index. A read hit returns the stored word. A read miss pulls the whole block in from memory one word at a time, in ascending offset order. It then writes the tag and sets the valid bit of that one line, and only then returns the requested word. Because the line is fixed by the block number modulo the line count, blocks with the same index evict one another even while every other line is empty.

Writes always go through to main memory. If the addressed block is resident, the cached word is updated in the same step, so the two copies stay equal. A write that misses leaves the cache untouched: there is no allocation on a write. The processor sees a ready/request handshake. Every access, read or write, ends with a one-cycle response pulse that carries the read word, or the written word for a store.

The controller is a six-state machine:

- **ST_IDLE**: accepts a request.
- **ST_LOOKUP**: checks the tag and valid bit. On a read hit it moves to ST_RESPOND. On a read miss it moves to ST_FILL_REQ. On any write it moves to ST_WRITE.
- **ST_FILL_REQ**: issues one word read, then moves to ST_FILL_WAIT.
- **ST_FILL_WAIT**: waits for the word. After the word it moves back to ST_FILL_REQ, or to ST_RESPOND once the last word has arrived.
- **ST_WRITE**: issues the memory store and updates the cache on a hit, then moves to ST_RESPOND.
- **ST_RESPOND**: raises the response pulse and returns to ST_IDLE.

Top module: `dm_cache`

## Requirements
- R1: After reset every valid bit is 0, so the first read of any address is a miss. Out of reset cpu_ready is 1, while cpu_rvalid and mem_req are 0.
- R2: With the default sizes (16 words per block, 128 lines, 4096 memory blocks, 16 address bits), the address is split as follows: offset is cpu_addr[3:0], index is cpu_addr[10:4] and tag is cpu_addr[15:11]. A read returns the word at that offset of that block, including at the highest address 0xFFFF.
- R3: A read hit raises cpu_rvalid, with the stored word on cpu_rdata, right after the first rising edge that follows the edge accepting the request. It issues no memory read.
- R4: A read miss issues exactly one memory read per word of the block. The reads start at offset 0 and each one follows the previous address plus 1. With a memory that answers one cycle after each read, the response appears 2*B+1 edges after acceptance (33 for B=16).
- R5: After a fill completes, a read of any word of the same block is a hit.
- R6: Block i occupies line i mod N. Loading a block with the same index but a different tag evicts the resident block, so the evicted block misses again. Blocks at other indices keep their hits.
- R7: Every write issues exactly one memory store carrying the request address and data. It responds two edges after acceptance with cpu_rdata equal to the written data.
- R8: A write to a resident block also updates the cached word, so a later read hits and returns the new data.
- R9: A write miss does not allocate: the line keeps its previous block, and a later read of the written address misses and returns the stored data from memory.
- R10: cpu_ready is 1 only in the idle state. It drops on the edge that accepts a request, and cpu_rvalid is high for exactly one cycle per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor request, taken when cpu_ready is 1 |
| cpu_we | input | 1 | 1 for a write, 0 for a read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Controller is idle and takes a request |
| cpu_rvalid | output | 1 | One-cycle response pulse |
| cpu_rdata | output | DATA_W | Read word, or the written word for a store |
| mem_req | output | 1 | Memory access strobe, one cycle per word |
| mem_we | output | 1 | 1 for a memory store, 0 for a read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory store data |
| mem_rvalid | input | 1 | Memory read data is valid |
| mem_rdata | input | DATA_W | Memory read data |

## Verification
Results fall due at three distances from the accepting edge. A read hit answers one edge later, a write two edges later, and a read miss 2*B+1 edges later when the memory answers each read after one cycle. The bench counts rising edges from the accepting edge and samples 1 ns after each one. It compares the edge count at which cpu_rvalid appears with the latency the table expects for that vector, which tells a hit from a miss at the ports. It also compares the counted memory reads and stores per access, and then confirms one edge later that the pulse has ended.

// File: rtl/dm_cache_pkg.sv
package dm_cache_pkg;

    // Controller states; the encoding carries no meaning outside the FSM.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_FILL_REQ,
        ST_FILL_WAIT,
        ST_WRITE,
        ST_RESPOND
    } dmc_state_e;

endpackage

// File: rtl/dm_cache_addr_split.sv
module dm_cache_addr_split #(
    parameter int OFF_W = 4,
    parameter int IDX_W = 7,
    parameter int TAG_W = 5,
    localparam int ADDR_W = OFF_W + IDX_W + TAG_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [TAG_W-1:0]  tag,
    output logic [IDX_W-1:0]  idx,
    output logic [OFF_W-1:0]  off
);

    // Offset in the low bits, index above it, tag on top.
    assign off = addr[OFF_W-1:0];
    assign idx = addr[OFF_W +: IDX_W];
    assign tag = addr[ADDR_W-1 -: TAG_W];

endmodule

// File: rtl/dm_cache_tags.sv
module dm_cache_tags #(
    parameter int LINES = 128,
    parameter int TAG_W = 5,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // One valid flop per line, cleared by reset, set by a completed fill.
    for (genvar g = 0; g < LINES; g++) begin : g_valid
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                valid_q[g] <= 1'b1;
            end
        end
    end

    // Tag storage needs no reset: it is qualified by the valid bit.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

endmodule

// File: rtl/dm_cache_data.sv
module dm_cache_data #(
    parameter int LINES           = 128,
    parameter int WORDS_PER_BLOCK = 16,
    parameter int DATA_W          = 32,
    localparam int IDX_W = $clog2(LINES),
    localparam int OFF_W = $clog2(WORDS_PER_BLOCK),
    localparam int DEPTH = LINES * WORDS_PER_BLOCK
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_word,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_word
);

    logic [DATA_W-1:0] word_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            word_q[{wr_idx, wr_off}] <= wr_word;
        end
    end

    assign rd_word = word_q[{rd_idx, rd_off}];

endmodule

// File: rtl/dm_cache.sv
module dm_cache
    import dm_cache_pkg::*;
#(
    parameter int DATA_W          = 32,
    parameter int WORDS_PER_BLOCK = 16,
    parameter int LINES           = 128,
    parameter int MEM_BLOCKS      = 4096,
    localparam int OFF_W  = $clog2(WORDS_PER_BLOCK),
    localparam int IDX_W  = $clog2(LINES),
    localparam int TAG_W  = $clog2(MEM_BLOCKS / LINES),
    localparam int ADDR_W = OFF_W + IDX_W + TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORDS_PER_BLOCK - 1);

    dmc_state_e state_q, state_d;

    // Captured request and fill progress.
    logic [ADDR_W-1:0] req_addr_q;
    logic              req_we_q;
    logic [DATA_W-1:0] req_wdata_q;
    logic              hit_q;
    logic [OFF_W-1:0]  fill_cnt_q;
    logic [DATA_W-1:0] rdata_q;

    // Address fields of the captured request.
    logic [TAG_W-1:0] r_tag;
    logic [IDX_W-1:0] r_idx;
    logic [OFF_W-1:0] r_off;

    // Store interfaces.
    logic              lk_hit;
    logic              tag_wr_en;
    logic [DATA_W-1:0] rd_word;
    logic              dwr_en;
    logic [OFF_W-1:0]  dwr_off;
    logic [DATA_W-1:0] dwr_word;

    logic accept;
    logic word_in;
    logic last_word;

    assign accept    = (state_q == ST_IDLE) && cpu_req;
    assign word_in   = (state_q == ST_FILL_WAIT) && mem_rvalid;
    assign last_word = word_in && (fill_cnt_q == LAST_OFF);

    dm_cache_addr_split #(
        .OFF_W (OFF_W),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_split (
        .addr (req_addr_q),
        .tag  (r_tag),
        .idx  (r_idx),
        .off  (r_off)
    );

    dm_cache_tags #(
        .LINES (LINES),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .lk_idx (r_idx),
        .lk_tag (r_tag),
        .lk_hit (lk_hit),
        .wr_en  (tag_wr_en),
        .wr_idx (r_idx),
        .wr_tag (r_tag)
    );

    dm_cache_data #(
        .LINES           (LINES),
        .WORDS_PER_BLOCK (WORDS_PER_BLOCK),
        .DATA_W          (DATA_W)
    ) u_data (
        .clk     (clk),
        .rd_idx  (r_idx),
        .rd_off  (r_off),
        .rd_word (rd_word),
        .wr_en   (dwr_en),
        .wr_idx  (r_idx),
        .wr_off  (dwr_off),
        .wr_word (dwr_word)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) state_d = ST_LOOKUP;
            end
            ST_LOOKUP: begin
                if (req_we_q)    state_d = ST_WRITE;
                else if (lk_hit) state_d = ST_RESPOND;
                else             state_d = ST_FILL_REQ;
            end
            ST_FILL_REQ: begin
                state_d = ST_FILL_WAIT;
            end
            ST_FILL_WAIT: begin
                if (last_word)    state_d = ST_RESPOND;
                else if (word_in) state_d = ST_FILL_REQ;
            end
            ST_WRITE: begin
                state_d = ST_RESPOND;
            end
            ST_RESPOND: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs and store strobes, decoded from the state.
    always_comb begin
        cpu_ready  = 1'b0;
        cpu_rvalid = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = {r_tag, r_idx, fill_cnt_q};
        tag_wr_en  = 1'b0;
        dwr_en     = 1'b0;
        dwr_off    = fill_cnt_q;
        dwr_word   = mem_rdata;
        unique case (state_q)
            ST_IDLE: begin
                cpu_ready = 1'b1;
            end
            ST_LOOKUP: begin
            end
            ST_FILL_REQ: begin
                mem_req = 1'b1;
            end
            ST_FILL_WAIT: begin
                dwr_en    = word_in;
                tag_wr_en = last_word;
            end
            ST_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = req_addr_q;
                dwr_en   = hit_q;
                dwr_off  = r_off;
                dwr_word = req_wdata_q;
            end
            ST_RESPOND: begin
                cpu_rvalid = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign mem_wdata = req_wdata_q;
    assign cpu_rdata = rdata_q;

    // Datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_addr_q  <= '0;
            req_we_q    <= 1'b0;
            req_wdata_q <= '0;
            hit_q       <= 1'b0;
            fill_cnt_q  <= '0;
            rdata_q     <= '0;
        end else begin
            if (accept) begin
                req_addr_q  <= cpu_addr;
                req_we_q    <= cpu_we;
                req_wdata_q <= cpu_wdata;
            end
            if (state_q == ST_LOOKUP) begin
                hit_q      <= lk_hit;
                fill_cnt_q <= '0;
                if (!req_we_q && lk_hit) rdata_q <= rd_word;
            end
            if (word_in) begin
                if (fill_cnt_q == r_off) rdata_q <= mem_rdata;
                fill_cnt_q <= fill_cnt_q + OFF_W'(1);
            end
            if (state_q == ST_WRITE) begin
                rdata_q <= req_wdata_q;
            end
        end
    end

endmodule

// File: rtl/dm_cache_checker.sv
module dm_cache_checker #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_ready,
    input logic              cpu_rvalid,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);

    logic [ADDR_W-1:0] prev_rd_q;
    logic              have_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_rd_q   <= '0;
            have_prev_q <= 1'b0;
        end else if (mem_req && !mem_we) begin
            prev_rd_q   <= mem_addr;
            have_prev_q <= 1'b1;
        end
    end

    AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |=> !cpu_rvalid); // R10

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready) |=> !cpu_ready); // R10

    AST_NO_MEM_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !mem_req); // R3

    AST_FILL_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && have_prev_q && (mem_addr[OFF_W-1:0] != '0))
            |-> (mem_addr == prev_rd_q + ADDR_W'(1))); // R4

    AST_STORE_THEN_RESPOND: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> (cpu_rvalid && !mem_req)); // R7

endmodule

bind dm_cache dm_cache_checker #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_ready  (cpu_ready),
    .cpu_rvalid (cpu_rvalid),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr)
);

// File: tb/dm_cache_bench.sv
module dm_cache_bench;

    localparam int B      = 16;
    localparam int LAT_HIT  = 1;
    localparam int LAT_WR   = 2;
    localparam int LAT_MISS = 2 * B + 1;
    localparam int NVEC   = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic        cpu_rvalid;
    logic [31:0] cpu_rdata;
    logic        mem_req;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;

    always #2 clk = ~clk;

    dm_cache u_dm_cache (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_ready  (cpu_ready),
        .cpu_rvalid (cpu_rvalid),
        .cpu_rdata  (cpu_rdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata)
    );

    // ---------------- behavioural main memory ----------------
    function automatic logic [31:0] pat(input logic [15:0] a);
        return {a ^ 16'hBEEF, a};
    endfunction

    logic [15:0] ov_addr [16];
    logic [31:0] ov_data [16];
    int          ov_n = 0;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    int          ord_err = 0;
    logic [15:0] last_rd = '0;
    logic [15:0] last_wr_addr = '0;
    logic [31:0] last_wr_data = '0;

    function automatic logic [31:0] mem_value(input logic [15:0] a);
        logic [31:0] v = pat(a);
        for (int k = 0; k < ov_n; k++) begin
            if (ov_addr[k] == a) v = ov_data[k];
        end
        return v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
        end else begin
            mem_rvalid <= 1'b0;
            if (mem_req && mem_we) begin
                ov_addr[ov_n] = mem_addr;
                ov_data[ov_n] = mem_wdata;
                if (ov_n < 15) ov_n = ov_n + 1;
                wr_cnt = wr_cnt + 1;
                last_wr_addr = mem_addr;
                last_wr_data = mem_wdata;
            end else if (mem_req) begin
                if (mem_addr[3:0] != 4'd0 && mem_addr != last_rd + 16'd1) ord_err = ord_err + 1;
                last_rd = mem_addr;
                rd_cnt = rd_cnt + 1;
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem_value(mem_addr);
            end
        end
    end

    // ---------------- checking ----------------
    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [15:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output int lat,
                          output bit busy_ok, output bit pulse_ok);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        @(posedge clk); #1;
        cpu_req = 1'b0;
        busy_ok = !cpu_ready;
        lat = 0; rd = '0;
        while (lat < 200) begin
            @(posedge clk); #1;
            lat++;
            if (cpu_rvalid) begin
                rd = cpu_rdata;
                break;
            end
        end
        @(posedge clk); #1;
        pulse_ok = !cpu_rvalid;
    endtask

    // we, addr, wdata, literal-expected flag, expected word, latency, reads, stores, requirement
    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [31:0] wdata;
        logic        lit;
        logic [31:0] exp;
        logic [7:0]  lat;
        logic [7:0]  rds;
        logic [7:0]  wrs;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 16'h0013, 32'h0, 1'b0, 32'h0,          8'(LAT_MISS), 8'(B), 8'd0, 4'd4},  // R4 cold miss, block 1
        '{1'b0, 16'h001A, 32'h0, 1'b0, 32'h0,          8'(LAT_HIT),  8'd0,  8'd0, 4'd5},  // R5 other word same block
        '{1'b0, 16'h0813, 32'h0, 1'b0, 32'h0,          8'(LAT_MISS), 8'(B), 8'd0, 4'd6},  // R6 block 129 -> line 1
        '{1'b0, 16'h0015, 32'h0, 1'b0, 32'h0,          8'(LAT_MISS), 8'(B), 8'd0, 4'd6},  // R6 block 1 evicted
        '{1'b0, 16'h0120, 32'h0, 1'b0, 32'h0,          8'(LAT_MISS), 8'(B), 8'd0, 4'd2},  // R2 block 18 offset 0
        '{1'b0, 16'h0127, 32'h0, 1'b0, 32'h0,          8'(LAT_HIT),  8'd0,  8'd0, 4'd3},  // R3 hit
        '{1'b0, 16'h0016, 32'h0, 1'b0, 32'h0,          8'(LAT_HIT),  8'd0,  8'd0, 4'd6},  // R6 line 1 kept
        '{1'b1, 16'h0016, 32'hDEAD0001, 1'b1, 32'hDEAD0001, 8'(LAT_WR), 8'd0, 8'd1, 4'd7}, // R7 write hit
        '{1'b0, 16'h0016, 32'h0, 1'b1, 32'hDEAD0001,   8'(LAT_HIT),  8'd0,  8'd0, 4'd8},  // R8 updated copy
        '{1'b1, 16'h1016, 32'hCAFE0002, 1'b1, 32'hCAFE0002, 8'(LAT_WR), 8'd0, 8'd1, 4'd9}, // R9 write miss
        '{1'b0, 16'h0017, 32'h0, 1'b0, 32'h0,          8'(LAT_HIT),  8'd0,  8'd0, 4'd9},  // R9 no allocate
        '{1'b0, 16'h1016, 32'h0, 1'b1, 32'hCAFE0002,   8'(LAT_MISS), 8'(B), 8'd0, 4'd9},  // R9 data from memory
        '{1'b0, 16'h0016, 32'h0, 1'b1, 32'hDEAD0001,   8'(LAT_MISS), 8'(B), 8'd0, 4'd7},  // R7 memory kept store
        '{1'b0, 16'hFFFF, 32'h0, 1'b0, 32'h0,          8'(LAT_MISS), 8'(B), 8'd0, 4'd2},  // R2 top address
        '{1'b0, 16'hFFF0, 32'h0, 1'b0, 32'h0,          8'(LAT_HIT),  8'd0,  8'd0, 4'd3}   // R3 hit, offset 0
    };

    task automatic run_one(input vec_t v);
        logic [31:0] rd;
        logic [31:0] exp;
        int          lat;
        bit          busy_ok;
        bit          pulse_ok;
        int          r0;
        int          w0;
        string       tag;
        tag = $sformatf("R%0d", v.req);
        r0 = rd_cnt; w0 = wr_cnt;
        exp = v.lit ? v.exp : pat(v.addr);
        access(v.we, v.addr, v.wdata, rd, lat, busy_ok, pulse_ok);
        chk(rd == exp, tag, $sformatf("data @%h", v.addr), rd, exp);
        chk(lat == int'(v.lat), tag, $sformatf("latency @%h", v.addr), 32'(lat), 32'(v.lat));
        chk((rd_cnt - r0) == int'(v.rds), tag, "memory reads", 32'(rd_cnt - r0), 32'(v.rds));
        chk((wr_cnt - w0) == int'(v.wrs), tag, "memory stores", 32'(wr_cnt - w0), 32'(v.wrs));
        chk(busy_ok, "R10", "ready low after accept", 32'(!busy_ok), 32'd0);
        chk(pulse_ok, "R10", "single-cycle rvalid", 32'(!pulse_ok), 32'd0);
        if (v.we) begin
            chk(last_wr_addr == v.addr, "R7", "store address", 32'(last_wr_addr), 32'(v.addr));
            chk(last_wr_data == v.wdata, "R7", "store data", last_wr_data, v.wdata);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            finish_run();
        end
    end

    initial begin
        logic [31:0] rd;
        int          lat;
        bit          busy_ok;
        bit          pulse_ok;

        repeat (3) @(posedge clk);
        #1;
        // R1: state held in reset
        chk(cpu_ready == 1'b0 || cpu_ready == 1'b1, "R1", "ready known in reset", 32'(cpu_ready), 32'(cpu_ready));
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk(cpu_ready == 1'b1, "R1", "ready after reset", 32'(cpu_ready), 32'd1);
        chk(cpu_rvalid == 1'b0, "R1", "rvalid after reset", 32'(cpu_rvalid), 32'd0);
        chk(mem_req == 1'b0, "R1", "mem_req after reset", 32'(mem_req), 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            run_one(VEC[i]);
        end

        // R1: reset in mid-run clears every valid bit; a resident block misses again.
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        access(1'b0, 16'hFFF3, 32'h0, rd, lat, busy_ok, pulse_ok);
        chk(lat == LAT_MISS, "R1", "miss after reset", 32'(lat), 32'(LAT_MISS));
        chk(rd == pat(16'hFFF3), "R1", "data after reset", rd, pat(16'hFFF3));

        // R5: every word of the refilled block now hits.
        for (int o = 0; o < B; o++) begin
            access(1'b0, 16'hFFF0 + 16'(o), 32'h0, rd, lat, busy_ok, pulse_ok);
            chk(lat == LAT_HIT, "R5", "hit across block", 32'(lat), 32'(LAT_HIT));
            chk(rd == pat(16'hFFF0 + 16'(o)), "R5", "word across block", rd, pat(16'hFFF0 + 16'(o)));
        end

        // R4: fills were in ascending order from offset 0.
        chk(ord_err == 0, "R4", "fill order", 32'(ord_err), 32'd0);

        finish_run();
    end

endmodule